// File: doc/BRIEF.md
# Timeout-Framed Two-Wire Register Slave

This block is the slave end of a two-wire serial port: one clock line driven by the host and one bidirectional data line. Each transfer opens with a one-byte header, a direction bit followed by a seven-bit register address. A write then carries one data byte into the addressed register. A read makes the slave take the data line and shift the register contents back to the host. There is no select line. Word alignment is recovered instead by an inactivity timer on the serial clock. When the clock has been quiet long enough, any partial transfer is dropped and the next clock edge starts a new header. This lets a host that has lost step recover by simply pausing.

A small register file sits behind the port. Register 0x00 is the configuration register. Its top bit is a soft reset. Writing it with that bit set resets the digital section to its power-up state, but the remaining bits of the same byte stay in the register and the reset bit clears itself. A settle counter counts frame ticks after any reset and raises a settled flag once enough frames have gone by.

Both serial inputs cross into the system clock through two-flop synchronisers before any edge is detected. The timeout, register count and settle length are parameters.

Top module: `sport_slave`

## Requirements
- R1: A transfer starts with a direction bit (1 = write, 0 = read) and then seven address bits, most significant first. SDIO is sampled on rising SCK edges, and SCK idles high.
- R2: On a write, eight data bits follow MSB first and are stored in the addressed register. Only addresses 0 to NUM_REGS-1 (default 0..3) exist. A write to any other address changes no register, and a read of it returns 0x00.
- R3: On a read, the slave raises sdioOe on the first falling SCK edge after the address. It presents data bits 7 down to 0, each changed on a falling SCK edge. It drops sdioOe after the eighth data rising edge.
- R4: If SCK shows no edge for TIMEOUT_CYCLES system clocks (default 100), any partial transfer is discarded, sdioOe is released and the next edge begins a new header.
- R5: After rstN is released, SCK activity is ignored until one timeout period of SCK inactivity has elapsed.
- R6: A write to address 0x00 with bit 7 set triggers a soft reset. The soft reset clears all other registers, forgets any transfer in progress, requires a fresh timeout before SCK is obeyed, and restarts the settle count.
- R7: Bits 6..0 of the byte that triggered a soft reset remain in the configuration register, and bit 7 clears itself without a further write. cfgValue shows the configuration register.
- R8: settled is low after any reset and goes high on the cycle after the SETTLE_FRAMES-th frameTick (default 3). It stays high until the next reset.
- R9: While rstN is low, sdioOe is 0, cfgValue is 0x00 and settled is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous power-up reset, active low |
| frameTick | input | 1 | One-cycle pulse per frame, used for settling |
| sck | input | 1 | Serial clock from the host, idles high |
| sdioIn | input | 1 | Serial data arriving from the host |
| sdioOut | output | 1 | Serial data driven by the slave during reads |
| sdioOe | output | 1 | Output enable for sdioOut |
| cfgValue | output | 8 | Current configuration register contents |
| settled | output | 1 | High once the settle frame count has elapsed |

## Verification
The bench clocks a full write straight after reset. A port that obeyed SCK before its first timeout would store that byte, and a later read would show it. A half-sent header followed by a pause checks resynchronisation. Without the timeout, the stale bits would shift the next address and data, and the wrong register would change. A write to address 9 catches a decoder that truncates the address, because such a decoder would alias address 9 onto register 1. Soft-reset writes check three faults: a design that stored the whole byte, one that wiped the low bits, and one that left other registers or the settled flag alone. Each of these shows up in cfgValue or in a readback.

// File: rtl/sport_pkg.sv
package sport_pkg;

  // Strobes from the serial control to the register datapath
  typedef struct packed {
    logic       sdioBit;    // synchronised data line
    logic       shiftHdr;   // header bit (not last)
    logic       latchHdr;   // last address bit: header complete
    logic       shiftData;  // write data bit (not last)
    logic       commitWr;   // last write data bit
    logic       driveBit;   // falling edge in read data phase
    logic [2:0] bitSel;     // which read bit to present
    logic       endXfer;    // release the line, transfer over
  } ctlStrobe_t;

endpackage

// File: rtl/sport_ctrl.sv
module sport_ctrl
  import sport_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       softRst,
  input  logic       sck,
  input  logic       sdioIn,
  input  logic       isWrite,
  output ctlStrobe_t ctl
);

  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYCLES);
  localparam logic [CNT_W-1:0] LIMIT_M1 = CNT_W'(TIMEOUT_CYCLES - 1);

  logic [1:0] sckSync;
  logic [1:0] sdioSync;
  logic       sckPrev;
  logic [CNT_W-1:0] idleCnt;
  logic       armed;
  logic [3:0] bitCount;

  logic sckRise, sckFall, anyEdge, timeoutHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync  <= 2'b11;
      sdioSync <= 2'b00;
      sckPrev  <= 1'b1;
    end else begin
      sckSync  <= {sckSync[0], sck};
      sdioSync <= {sdioSync[0], sdioIn};
      sckPrev  <= sckSync[1];
    end
  end

  assign sckRise    = sckSync[1] & ~sckPrev;
  assign sckFall    = ~sckSync[1] & sckPrev;
  assign anyEdge    = sckRise | sckFall;
  assign timeoutHit = !anyEdge && (idleCnt == LIMIT_M1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt  <= '0;
      armed    <= 1'b0;
      bitCount <= '0;
    end else if (softRst) begin
      idleCnt  <= '0;
      armed    <= 1'b0;
      bitCount <= '0;
    end else begin
      if (anyEdge)
        idleCnt <= '0;
      else if (idleCnt != LIMIT)
        idleCnt <= idleCnt + 1'b1;

      if (timeoutHit) begin
        armed    <= 1'b1;
        bitCount <= '0;
      end else if (armed && sckRise) begin
        bitCount <= bitCount + 1'b1;
      end
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.sdioBit = sdioSync[1];
    ctl.bitSel  = ~bitCount[2:0];
    if (armed && !softRst && sckRise) begin
      if (!bitCount[3]) begin
        if (bitCount[2:0] == 3'd7) ctl.latchHdr = 1'b1;
        else                       ctl.shiftHdr = 1'b1;
      end else if (isWrite) begin
        if (bitCount == 4'd15) ctl.commitWr  = 1'b1;
        else                   ctl.shiftData = 1'b1;
      end
      if (bitCount == 4'd15) ctl.endXfer = 1'b1;
    end
    if (armed && !softRst && sckFall && bitCount[3] && !isWrite)
      ctl.driveBit = 1'b1;
    if (timeoutHit)
      ctl.endXfer = 1'b1;
  end

endmodule

// File: rtl/sport_regs.sv
module sport_regs
  import sport_pkg::*;
#(
  parameter int NUM_REGS      = 4,
  parameter int SETTLE_FRAMES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameTick,
  input  ctlStrobe_t ctl,
  output logic       isWrite,
  output logic       softRst,
  output logic       sdioOut,
  output logic       sdioOe,
  output logic [7:0] cfgValue,
  output logic       settled
);

  localparam int ADDR_W   = 7;
  localparam int CFG_ADDR = 0;
  localparam int SET_W    = $clog2(SETTLE_FRAMES + 1);
  localparam logic [SET_W-1:0] SET_DONE = SET_W'(SETTLE_FRAMES);

  logic [6:0]        hdrSh;
  logic [6:0]        dataSh;
  logic [ADDR_W-1:0] addrReg;
  logic              dirReg;
  logic [7:0]        rdByte;
  logic [7:0]        rdNext;
  logic              outBit;
  logic              oeReg;
  logic [SET_W-1:0]  settleCnt;
  logic [ADDR_W-1:0] hdrAddr;
  logic [7:0]        wrData;
  logic [NUM_REGS-1:0][7:0] regFile;

  assign hdrAddr = {hdrSh[5:0], ctl.sdioBit};
  assign wrData  = {dataSh, ctl.sdioBit};

  always_comb begin
    rdNext = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (hdrAddr == ADDR_W'(i)) rdNext = regFile[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrSh   <= '0;
      dataSh  <= '0;
      addrReg <= '0;
      dirReg  <= 1'b0;
      rdByte  <= '0;
      outBit  <= 1'b0;
      oeReg   <= 1'b0;
    end else if (softRst) begin
      hdrSh   <= '0;
      dataSh  <= '0;
      addrReg <= '0;
      dirReg  <= 1'b0;
      rdByte  <= '0;
      outBit  <= 1'b0;
      oeReg   <= 1'b0;
    end else begin
      if (ctl.shiftHdr)  hdrSh  <= {hdrSh[5:0], ctl.sdioBit};
      if (ctl.shiftData) dataSh <= {dataSh[5:0], ctl.sdioBit};
      if (ctl.latchHdr) begin
        addrReg <= hdrAddr;
        dirReg  <= hdrSh[6];
        rdByte  <= rdNext;
      end
      if (ctl.driveBit) begin
        outBit <= rdByte[ctl.bitSel];
        oeReg  <= 1'b1;
      end
      if (ctl.endXfer) oeReg <= 1'b0;
    end
  end

  // One storage slice per register; the configuration slot keeps its low bits
  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    logic [7:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        q <= '0;
      else if (softRst)
        q <= (g == CFG_ADDR) ? {1'b0, q[6:0]} : 8'h00;
      else if (ctl.commitWr && addrReg == ADDR_W'(g))
        q <= wrData;
    end
    assign regFile[g] = q;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 settleCnt <= '0;
    else if (softRst)                          settleCnt <= '0;
    else if (frameTick && settleCnt != SET_DONE) settleCnt <= settleCnt + 1'b1;
  end

  assign softRst  = regFile[CFG_ADDR][7];
  assign isWrite  = dirReg;
  assign sdioOut  = outBit;
  assign sdioOe   = oeReg;
  assign cfgValue = regFile[CFG_ADDR];
  assign settled  = (settleCnt == SET_DONE);

endmodule

// File: rtl/sport_slave.sv
module sport_slave
  import sport_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 100,
  parameter int NUM_REGS       = 4,
  parameter int SETTLE_FRAMES  = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameTick,
  input  logic       sck,
  input  logic       sdioIn,
  output logic       sdioOut,
  output logic       sdioOe,
  output logic [7:0] cfgValue,
  output logic       settled
);

  ctlStrobe_t ctl;
  logic       isWrite;
  logic       softRst;

  sport_ctrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .softRst(softRst), .sck(sck),
    .sdioIn(sdioIn), .isWrite(isWrite), .ctl(ctl)
  );

  sport_regs #(.NUM_REGS(NUM_REGS), .SETTLE_FRAMES(SETTLE_FRAMES)) u_regs (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .ctl(ctl),
    .isWrite(isWrite), .softRst(softRst), .sdioOut(sdioOut),
    .sdioOe(sdioOe), .cfgValue(cfgValue), .settled(settled)
  );

endmodule

// File: rtl/sport_slave_chk.sv
module sport_slave_chk
  import sport_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       softRst,
  input logic       frameTick,
  input logic       settled,
  input logic       sdioOe,
  input logic [7:0] cfgValue,
  input ctlStrobe_t ctl
);

  // R7
  reset_bit_self_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgValue[7] |=> !cfgValue[7]);

  // R6
  soft_reset_effect_chk: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (!settled && !sdioOe));

  // R8
  settled_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (settled && !softRst) |=> settled);

  // R8
  settled_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(settled) |-> $past(frameTick));

  // R4
  line_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.endXfer |=> !sdioOe);

endmodule

bind sport_slave sport_slave_chk u_chk (
  .clk(clk), .rstN(rstN), .softRst(softRst), .frameTick(frameTick),
  .settled(settled), .sdioOe(sdioOe), .cfgValue(cfgValue), .ctl(ctl)
);

// File: tb/test_sport_slave.sv
module test_sport_slave;

  localparam int CLK_PERIOD = 10;
  localparam int TIMEOUT    = 100;
  localparam int HALF       = 8;
  localparam int GAP        = TIMEOUT + 20;
  localparam int NVEC       = 5;
  // {address, write data, expected readback}
  localparam logic [23:0] VEC [NVEC] = '{
    24'h01A5A5, 24'h023C3C, 24'h03FFFF, 24'h001515, 24'h097700
  };

  logic clk = 1'b0;
  logic rstN, frameTick, sck, sdioIn;
  logic sdioOut, sdioOe, settled;
  logic [7:0] cfgValue;
  int nRun = 0, nFail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sport_slave #(.TIMEOUT_CYCLES(TIMEOUT), .NUM_REGS(4), .SETTLE_FRAMES(3)) i_sport_slave (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .sck(sck), .sdioIn(sdioIn),
    .sdioOut(sdioOut), .sdioOe(sdioOe), .cfgValue(cfgValue), .settled(settled)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    sck = 1'b0; sdioIn = b; waitClk(HALF);
    sck = 1'b1; waitClk(HALF);
  endtask

  task automatic writeReg(input logic [7:0] addr, input logic [7:0] data);
    sendBit(1'b1);
    for (int i = 6; i >= 0; i--) sendBit(addr[i]);
    for (int i = 7; i >= 0; i--) sendBit(data[i]);
    waitClk(GAP);
  endtask

  task automatic readReg(input logic [7:0] addr, output logic [7:0] val, output logic oeOk);
    sendBit(1'b0);
    for (int i = 6; i >= 0; i--) sendBit(addr[i]);
    oeOk = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; waitClk(HALF);
      val[i] = sdioOut;
      if (sdioOe !== 1'b1) oeOk = 1'b0;
      sck = 1'b1; waitClk(HALF);
    end
    waitClk(GAP);
    if (sdioOe !== 1'b0) oeOk = 1'b0;
  endtask

  task automatic tick();
    frameTick = 1'b1; waitClk(1);
    frameTick = 1'b0; waitClk(1);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic ok;
    rstN = 1'b0; frameTick = 1'b0; sck = 1'b1; sdioIn = 1'b0;
    waitClk(5);
    check("R9 sdioOe", {7'd0, sdioOe}, 8'h00);
    check("R9 cfgValue", cfgValue, 8'h00);
    check("R9 settled", {7'd0, settled}, 8'h00);
    rstN = 1'b1;

    // R5: a write sent before the first timeout must be ignored
    writeReg(8'h01, 8'h55);
    readReg(8'h01, v, ok);
    check("R5 early write ignored", v, 8'h00);

    // R8 settle count after power-up
    tick(); tick();
    check("R8 not settled after 2", {7'd0, settled}, 8'h00);
    tick();
    check("R8 settled after 3", {7'd0, settled}, 8'h01);

    // R1 R2 R3 vector table
    for (int k = 0; k < NVEC; k++) begin
      writeReg(VEC[k][23:16], VEC[k][15:8]);
      readReg(VEC[k][23:16], v, ok);
      check("R1 R2 readback", v, VEC[k][7:0]);
      check("R3 output enable", {7'd0, ok}, 8'h01);
    end
    readReg(8'h01, v, ok);
    check("R2 out-of-range write left reg1", v, 8'hA5);
    check("R2 cfgValue after write", cfgValue, 8'h15);

    // R4: partial header, pause, then a clean transfer
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    waitClk(GAP);
    check("R4 line released after timeout", {7'd0, sdioOe}, 8'h00);
    writeReg(8'h02, 8'h99);
    readReg(8'h02, v, ok);
    check("R4 resync write", v, 8'h99);
    readReg(8'h03, v, ok);
    check("R4 other register untouched", v, 8'hFF);

    // R6 R7: soft reset keeping low bits
    writeReg(8'h00, 8'h83);
    check("R7 cfg low bits kept, bit7 cleared", cfgValue, 8'h03);
    check("R6 settled cleared", {7'd0, settled}, 8'h00);
    readReg(8'h01, v, ok);
    check("R6 reg1 cleared", v, 8'h00);
    readReg(8'h02, v, ok);
    check("R6 reg2 cleared", v, 8'h00);
    readReg(8'h00, v, ok);
    check("R7 cfg readback", v, 8'h03);
    tick(); tick();
    check("R8 not settled 2 after soft reset", {7'd0, settled}, 8'h00);
    tick();
    check("R8 settled after soft reset", {7'd0, settled}, 8'h01);

    // R7 plain reset value
    writeReg(8'h00, 8'h80);
    check("R7 plain reset cfg", cfgValue, 8'h00);
    check("R6 settled cleared again", {7'd0, settled}, 8'h00);

    done = 1;
    summary();
    $finish;
  end

endmodule